// File: doc/BRIEF.md
# Phase-Shifted Carrier Gate Generator for a Cascaded Bridge Phase

This block drives the switches of one phase of a cascaded full-bridge inverter made of `NCELL` series cells. Each cell has its own triangular carrier. The carrier is a digital up/down counter, and the cells' carriers have the same amplitude and frequency but are evenly staggered in phase. Each cell compares a signed modulating sample with its carrier to set its first leg. It compares the negated sample with the same carrier to set its second leg. In that way each carrier also stands in for its 180-degree inverted partner, so the phase uses `2*NCELL` equally spaced carriers in total.

Every leg drives complementary upper and lower gates. A programmable dead time, counted in clock cycles, holds both gates off after each change of a leg's state. A signed level output gives the sum of the cell voltages in units of one cell supply, so the stepped phase waveform can be watched directly.

The modulation depth is set only by the sample amplitude relative to the carrier peak. The carrier peak is fixed while the block is held in reset.

Top module: `pscpwm_gen`

## Requirements
- R1: Each carrier counter stays within 0 to the latched peak, moves by one every clock, and turns around only at 0 or at the peak, so one carrier period is 2*peak clocks.
- R2: On leaving reset, cell k's counter starts at floor(k*peak/NCELL) and counts upward, so adjacent cells are spaced by 1/(2*NCELL) of a carrier period (60 degrees for three cells).
- R3: A cell takes a new modulating sample only on the clock where its counter equals the peak; at all other clocks its held sample does not change.
- R4: With the carrier value defined as 2*count - peak, the first-leg upper switch wants to be on while the held sample is strictly greater than the carrier, and the second-leg upper switch wants to be on while the negated held sample is strictly greater than the carrier.
- R5: Gate bits for cell k are: bit 4k first-leg upper, bit 4k+1 second-leg upper, bit 4k+2 first-leg lower, bit 4k+3 second-leg lower; outside dead time the lower gate of a leg is the complement of its upper gate, and the upper and lower gates of a leg are never on together.
- R6: When a leg's wanted state changes, both of its gates are off for exactly dead_cycles clocks (the value present at that change) before the new state appears; a change during that gap restarts it; with dead_cycles = 0 the new state appears at once. Gates are registered, so they follow the wanted state one clock later.
- R7: The level output equals the sum over the cells of +1 when bits 4k and 4k+3 are both on, -1 when bits 4k+1 and 4k+2 are both on, and 0 otherwise, and it always lies between -NCELL and +NCELL.
- R8: Over one full-index cycle of a sinusoidal sample with zero dead time, the level output takes all 2*NCELL+1 values.
- R9: half_period is captured only while reset is held; a value of 0 is treated as 1, and later changes have no effect until the next reset.
- R10: A held sample at or above the peak keeps the first-leg upper and second-leg lower on for the whole carrier, apart from the single point where the sample equals the peak; a held sample at or below minus the peak gives the mirror state.
- R11: While reset is held, all gates are off and the level is 0; after reset both legs start from the lower-on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; half_period is captured while it is low |
| mod_sample | input | CW+1 | Signed modulating sample, full scale equal to the carrier peak |
| half_period | input | CW | Carrier peak in counts (half a carrier period in clocks) |
| dead_cycles | input | DTW | Dead time in clocks applied after each leg change |
| gate | output | 4*NCELL | Switch gate drives, four per cell, layout as in R5 |
| level | output | LW | Signed phase level, sum of cell states |

## Verification
A constant zero sample shows that the two legs of each cell move together, so every cell stays at zero, and that the carriers are staggered in phase. A full-index sine with no dead time sweeps the staircase through every level. A sample that changes every clock separates latching at the peak from continuous tracking. Samples pinned at, above and below the peak exercise the saturated states. A sine with several dead-time settings, some of them changed mid-run, checks the gap and restart rule against the bench's own model. Changing half_period after reset, and a reset with half_period at zero, show that only the value captured in reset sets the carrier peak.

// File: rtl/pscpwm_gen.sv
`timescale 1ns/1ps
module pscpwm_gen #(
  parameter int NCELL = 3,
  parameter int CW    = 10,
  parameter int DTW   = 6,
  localparam int LW   = $clog2(NCELL + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [CW:0]     mod_sample,
  input  logic        [CW-1:0]   half_period,
  input  logic        [DTW-1:0]  dead_cycles,
  output logic        [4*NCELL-1:0] gate,
  output logic signed [LW-1:0]   level
);

  localparam int NLEG = 2 * NCELL;
  localparam int XW   = CW + 2;

  logic [CW-1:0] peak, peak_in;
  logic [NCELL-1:0][CW-1:0] ctr;
  logic [NCELL-1:0]         up;
  logic [NCELL-1:0][CW:0]   mod_q;
  logic [NLEG-1:0]          want, cur, hi, lo;
  logic [NLEG-1:0][DTW-1:0] cnt;

  assign peak_in = (half_period == '0) ? CW'(1) : half_period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak <= peak_in;
      for (int k = 0; k < NCELL; k++) begin
        ctr[k]   <= CW'((k * int'(peak_in)) / NCELL);
        up[k]    <= 1'b1;
        mod_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NCELL; k++) begin
        if (ctr[k] == peak) mod_q[k] <= mod_sample;
        if (up[k]) begin
          if (ctr[k] == peak) begin
            up[k]  <= 1'b0;
            ctr[k] <= peak - CW'(1);
          end else begin
            ctr[k] <= ctr[k] + CW'(1);
          end
        end else begin
          if (ctr[k] == '0) begin
            up[k]  <= 1'b1;
            ctr[k] <= CW'(1);
          end else begin
            ctr[k] <= ctr[k] - CW'(1);
          end
        end
      end
    end
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_cmp
    logic signed [XW-1:0] car, smp;
    assign car = $signed({1'b0, ctr[k], 1'b0}) - $signed({2'b00, peak});
    assign smp = $signed({mod_q[k][CW], mod_q[k]});
    assign want[2*k]   = smp > car;
    assign want[2*k+1] = -smp > car;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      cnt <= '0;
      hi  <= '0;
      lo  <= '0;
    end else begin
      for (int j = 0; j < NLEG; j++) begin
        if (want[j] != cur[j]) begin
          cur[j] <= want[j];
          cnt[j] <= dead_cycles;
          hi[j]  <= (dead_cycles == '0) &&  want[j];
          lo[j]  <= (dead_cycles == '0) && !want[j];
        end else if (cnt[j] != '0) begin
          cnt[j] <= cnt[j] - DTW'(1);
          if (cnt[j] == DTW'(1)) begin
            hi[j] <= cur[j];
            lo[j] <= !cur[j];
          end
        end else begin
          hi[j] <= cur[j];
          lo[j] <= !cur[j];
        end
      end
    end
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_map
    assign gate[4*k]   = hi[2*k];
    assign gate[4*k+1] = hi[2*k+1];
    assign gate[4*k+2] = lo[2*k];
    assign gate[4*k+3] = lo[2*k+1];
  end

  always_comb begin
    int s;
    s = 0;
    for (int k = 0; k < NCELL; k++) begin
      if (gate[4*k] && gate[4*k+3])        s = s + 1;
      else if (gate[4*k+1] && gate[4*k+2]) s = s - 1;
    end
    level = LW'(s);
  end

endmodule

// File: rtl/pscpwm_gen_chk.sv
`timescale 1ns/1ps
module pscpwm_gen_chk #(
  parameter int NCELL = 3,
  parameter int CW    = 10,
  parameter int DTW   = 6,
  parameter int LW    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [DTW-1:0]             dead_cycles,
  input logic [4*NCELL-1:0]         gate,
  input logic signed [LW-1:0]       level,
  input logic [CW-1:0]              peak,
  input logic [NCELL-1:0][CW-1:0]   ctr,
  input logic [NCELL-1:0][CW:0]     mod_q
);

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    a_r1_ctr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ctr[k] <= peak);

    a_r3_hold_off_peak: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctr[k]) != $past(peak)) |-> $stable(mod_q[k]));

    for (genvar s = 0; s < 2; s++) begin : g_leg
      a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate[4*k+s] && gate[4*k+2+s]));

      a_r6_gap_before_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate[4*k+s]) && $past(gate[4*k+2+s])) |-> ($past(dead_cycles) == '0));

      a_r6_gap_before_lower: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate[4*k+2+s]) && $past(gate[4*k+s])) |-> ($past(dead_cycles) == '0));
    end
  end

  a_r7_level_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LW'(NCELL)) && (level >= -LW'(NCELL)));

endmodule

bind pscpwm_gen pscpwm_gen_chk #(.NCELL(NCELL), .CW(CW), .DTW(DTW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dead_cycles(dead_cycles), .gate(gate),
  .level(level), .peak(peak), .ctr(ctr), .mod_q(mod_q)
);

// File: tb/tb_pscpwm_gen.sv
`timescale 1ns/1ps
module tb_pscpwm_gen;
  localparam int N   = 3;
  localparam int CW  = 10;
  localparam int DTW = 6;
  localparam int LW  = $clog2(N + 1) + 1;
  localparam int NL  = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [CW:0] mod_sample = '0;
  logic [CW-1:0] half_period = 10'd12;
  logic [DTW-1:0] dead_cycles = '0;
  logic [4*N-1:0] gate;
  logic signed [LW-1:0] level;

  always #4 clk = ~clk;

  pscpwm_gen #(.NCELL(N), .CW(CW), .DTW(DTW)) dut (
    .clk(clk), .rst_n(rst_n), .mod_sample(mod_sample), .half_period(half_period),
    .dead_cycles(dead_cycles), .gate(gate), .level(level)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R11";
  bit done = 0;

  int mpk;
  int mc [N], mup [N], mq [N];
  int lcur [NL], lcnt [NL], lhi [NL], llo [NL];

  always @(posedge clk) begin
    int w [NL];
    int car;
    if (!rst_n) begin
      mpk = (half_period == 0) ? 1 : int'(half_period);
      for (int k = 0; k < N; k++) begin
        mc[k] = (k * mpk) / N; mup[k] = 1; mq[k] = 0;
      end
      for (int j = 0; j < NL; j++) begin
        lcur[j] = 0; lcnt[j] = 0; lhi[j] = 0; llo[j] = 0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        car = 2 * mc[k] - mpk;
        w[2*k]   = (mq[k] > car) ? 1 : 0;
        w[2*k+1] = (-mq[k] > car) ? 1 : 0;
      end
      for (int j = 0; j < NL; j++) begin
        if (w[j] != lcur[j]) begin
          lcur[j] = w[j];
          lcnt[j] = int'(dead_cycles);
          if (lcnt[j] == 0) begin lhi[j] = w[j]; llo[j] = 1 - w[j]; end
          else begin lhi[j] = 0; llo[j] = 0; end
        end else if (lcnt[j] > 0) begin
          lcnt[j]--;
          if (lcnt[j] == 0) begin lhi[j] = lcur[j]; llo[j] = 1 - lcur[j]; end
        end else begin
          lhi[j] = lcur[j]; llo[j] = 1 - lcur[j];
        end
      end
      for (int k = 0; k < N; k++) begin
        if (mc[k] == mpk) mq[k] = int'(mod_sample);
        if (mup[k] == 1) begin
          if (mc[k] == mpk) begin mup[k] = 0; mc[k] = mpk - 1; end
          else mc[k]++;
        end else begin
          if (mc[k] == 0) begin mup[k] = 1; mc[k] = 1; end
          else mc[k]--;
        end
      end
    end
  end

  function automatic logic [4*N-1:0] exp_gate();
    logic [4*N-1:0] g;
    for (int k = 0; k < N; k++) begin
      g[4*k]   = lhi[2*k][0];
      g[4*k+1] = lhi[2*k+1][0];
      g[4*k+2] = llo[2*k][0];
      g[4*k+3] = llo[2*k+1][0];
    end
    return g;
  endfunction

  function automatic int exp_level();
    int s = 0;
    for (int k = 0; k < N; k++) begin
      if (lhi[2*k] == 1 && llo[2*k+1] == 1) s++;
      else if (lhi[2*k+1] == 1 && llo[2*k] == 1) s--;
    end
    return s;
  endfunction

  task automatic compare();
    logic [4*N-1:0] eg;
    int el;
    eg = exp_gate();
    el = exp_level();
    n_run++;
    if (gate !== eg) begin
      n_fail++;
      $display("FAIL %s gate actual=%b expected=%b t=%0t", tag, gate, eg, $time);
    end
    n_run++;
    if (int'(level) != el) begin
      n_fail++;
      $display("FAIL %s level actual=%0d expected=%0d t=%0t", tag, level, el, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input int hp);
    half_period = CW'(hp);
    rst_n = 1'b0;
    repeat (3) tick();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_sine(input int amp, input int per, input int cycles, input bit track,
                          inout bit [15:0] seen);
    for (int i = 0; i < cycles; i++) begin
      mod_sample = (CW+1)'($rtoi(real'(amp) * $sin(6.283185307 * real'(i) / real'(per))));
      tick();
      if (track) seen[int'(level) + N] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit [15:0] seen;
    int nseen;
    // R11: reset state
    tag = "R11";
    repeat (2) @(negedge clk);
    n_run++;
    if (gate !== '0 || level !== '0) begin
      n_fail++;
      $display("FAIL R11 reset gate=%b level=%0d expected gate=0 level=0", gate, level);
    end
    do_reset(12);

    // R2 offsets and R4 comparison with zero sample: every cell at zero
    tag = "R2/R4/R5";
    mod_sample = '0;
    repeat (60) tick();
    n_run++;
    if (level !== '0) begin
      n_fail++;
      $display("FAIL R4 zero sample level actual=%0d expected=0", level);
    end

    // R8: full-index sine, no dead time, staircase must reach every level
    tag = "R8/R7/R1";
    dead_cycles = '0;
    seen = '0;
    run_sine(12, 480, 960, 1'b1, seen);
    nseen = 0;
    for (int i = 0; i < 2*N+1; i++) if (seen[i]) nseen++;
    n_run++;
    if (nseen != 2*N+1) begin
      n_fail++;
      $display("FAIL R8 distinct levels actual=%0d expected=%0d", nseen, 2*N+1);
    end

    // R3: sample changes every clock, only peak values count
    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      mod_sample = (CW+1)'(((i * 37) % 25) - 12);
      tick();
    end

    // R10: saturation above, at and below the peak
    tag = "R10";
    mod_sample = (CW+1)'(17);
    repeat (60) tick();
    n_run++;
    if (level !== LW'(N)) begin
      n_fail++;
      $display("FAIL R10 over-peak level actual=%0d expected=%0d", level, N);
    end
    mod_sample = (CW+1)'(12);
    repeat (60) tick();
    mod_sample = -(CW+1)'(17);
    repeat (60) tick();
    n_run++;
    if (level !== -LW'(N)) begin
      n_fail++;
      $display("FAIL R10 under-peak level actual=%0d expected=%0d", level, -N);
    end

    // R6: dead time, including a change mid-run
    tag = "R6/R5";
    dead_cycles = 6'd2;
    run_sine(12, 240, 480, 1'b0, seen);
    dead_cycles = 6'd5;
    run_sine(9, 120, 360, 1'b0, seen);
    for (int i = 0; i < 200; i++) begin
      dead_cycles = DTW'(i % 4);
      mod_sample = (CW+1)'(((i * 13) % 21) - 10);
      tick();
    end
    dead_cycles = 6'd3;
    for (int i = 0; i < 100; i++) begin
      mod_sample = (i % 2 == 0) ? (CW+1)'(11) : -(CW+1)'(11);
      tick();
    end

    // R9: half_period change after reset is ignored
    tag = "R9";
    dead_cycles = '0;
    half_period = 10'd5;
    run_sine(12, 480, 480, 1'b0, seen);

    // R9: zero half_period behaves as one; R2 offsets with a new peak
    tag = "R9/R2";
    do_reset(0);
    run_sine(1, 48, 200, 1'b0, seen);
    tag = "R2/R1";
    do_reset(20);
    run_sine(20, 400, 800, 1'b0, seen);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule